// File: doc/BRIEF.md
# Programmable Periodic Interrupt Generator

This block derives a periodic event from a 32.768 kHz time base that reaches it as a one-cycle tick enable in the system clock domain. A 4-bit rate code picks a period that is a power of two ticks long. Each event sets a held periodic flag and produces a one-cycle strobe. It also raises a held interrupt request when periodic interrupts are enabled, and it emits a single-cycle pulse on the square-wave output when that output is enabled.

Events do not count from the moment the rate is programmed. A free-running 15-bit tick counter is shared by all rates, and an event fires when the counter steps onto an exact multiple of the selected period. A change of rate therefore takes effect on the next tick and keeps the phase relationship with the time base. The held flag and the interrupt request stay set until a clear strobe arrives; that strobe is the status read issued by the register interface.

Top module: `periodic_irq_gen`

## Requirements
- R1: With `rate_code` = 0 no event occurs: `flag_set`, `sqw_pulse` stay 0 and neither `pflag` nor `irq` is set.
- R2: For `rate_code` c in 3..15 the period is 2^(c-1) ticks of `tick_en`.
- R3: Rate codes 1 and 2 behave exactly like code 3, giving a period of 4 ticks.
- R4: Events occur only while `pie_en` is 1, or while both `sqw_en` and `sqw_attached` are 1.
- R5: The tick counter counts every tick from reset, whatever the rate or enables are. A tick produces an event when the counter value after that tick is a multiple of the period, so changing the rate or pausing the enables never shifts the alignment.
- R6: `pflag` is set by an event and held until a cycle with `flag_clr` = 1. When an event and a clear occur in the same cycle, the flag stays set.
- R7: `irq` is set only by an event that occurs while `pie_en` = 1. It is held until `flag_clr`, and a set in the same cycle as a clear wins.
- R8: `sqw_pulse` is 1 for exactly the one cycle after an event that occurs while `sqw_en` = 1, and is 0 otherwise.
- R9: `flag_set` is 1 for exactly the one cycle after each event. All outputs are registered and change on the clock edge that samples the tick.
- R10: After synchronous reset the counter is 0 and all four outputs are 0.
- R11: Cycles with `tick_en` = 0 neither advance the counter nor produce an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz time base rate |
| rate_code | input | 4 | Rate select; 0 stops events |
| pie_en | input | 1 | Periodic interrupt enable |
| sqw_en | input | 1 | Square-wave output enable |
| sqw_attached | input | 1 | A consumer is connected to the square-wave output |
| flag_clr | input | 1 | Clears `pflag` and `irq` (status read) |
| flag_set | output | 1 | One-cycle strobe per event |
| pflag | output | 1 | Held periodic flag |
| irq | output | 1 | Held interrupt request |
| sqw_pulse | output | 1 | One-cycle square-wave pulse per event |

## Verification
The bench builds the block with its default 15-bit counter and 4-bit rate code and drives a tick on most clock cycles. This makes even the longest period of 16384 ticks affordable, so every rate code from 0 to 15 is swept over at least two full periods. Extra passes toggle the enables mid-stream, change the rate at unaligned counter values, thin out the ticks, and place clears on event cycles. Together these reach the alignment, gating and set-over-clear corners.

// File: rtl/pig_pkg.sv
package pig_pkg;

  localparam int unsigned PIG_CODE_W = 4;

  // Effective shift (log2 of the period) for a non-zero rate code.
  // Codes below 3 alias to 3.
  function automatic logic [PIG_CODE_W-1:0] pig_shift(input logic [PIG_CODE_W-1:0] code);
    logic [PIG_CODE_W-1:0] eff;
    eff = (code < PIG_CODE_W'(3)) ? PIG_CODE_W'(3) : code;
    return eff - PIG_CODE_W'(1);
  endfunction

endpackage

// File: rtl/pig_rate_decode.sv
module pig_rate_decode #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 15
) (
  input  logic [CODE_W-1:0] code,
  output logic              active,
  output logic [CNT_W-1:0]  mask
);
  import pig_pkg::*;

  logic [CODE_W-1:0] shift;

  always_comb begin
    active = (code != '0);
    shift  = pig_shift(code);
  end

  // Low 'shift' bits of the counter must be zero for an event.
  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign mask[i] = (i < int'(shift));
  end

endmodule

// File: rtl/pig_tick_counter.sv
module pig_tick_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  output logic [CNT_W-1:0] cnt_next
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_next = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (tick_en) cnt_q <= cnt_next;
  end

endmodule

// File: rtl/pig_event_regs.sv
module pig_event_regs (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic pie_en,
  input  logic sqw_en,
  input  logic flag_clr,
  output logic flag_set,
  output logic pflag,
  output logic irq,
  output logic sqw_pulse
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_set  <= 1'b0;
      pflag     <= 1'b0;
      irq       <= 1'b0;
      sqw_pulse <= 1'b0;
    end else begin
      flag_set  <= evt;
      sqw_pulse <= evt & sqw_en;
      // A new event outranks a clear in the same cycle.
      pflag     <= evt | (pflag & ~flag_clr);
      irq       <= (evt & pie_en) | (irq & ~flag_clr);
    end
  end

endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              pie_en,
  input  logic              sqw_en,
  input  logic              sqw_attached,
  input  logic              flag_clr,
  output logic              flag_set,
  output logic              pflag,
  output logic              irq,
  output logic              sqw_pulse
);
  logic             code_active;
  logic [CNT_W-1:0] period_mask;
  logic [CNT_W-1:0] cnt_next;
  logic             running;
  logic             evt;

  pig_rate_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_decode (
    .code   (rate_code),
    .active (code_active),
    .mask   (period_mask)
  );

  pig_tick_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .cnt_next (cnt_next)
  );

  always_comb begin
    running = code_active & (pie_en | (sqw_en & sqw_attached));
    evt     = tick_en & running & ((cnt_next & period_mask) == '0);
  end

  pig_event_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .pie_en    (pie_en),
    .sqw_en    (sqw_en),
    .flag_clr  (flag_clr),
    .flag_set  (flag_set),
    .pflag     (pflag),
    .irq       (irq),
    .sqw_pulse (sqw_pulse)
  );

endmodule

// File: rtl/periodic_irq_gen_chk.sv
module periodic_irq_gen_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic [CODE_W-1:0] rate_code,
  input logic              pie_en,
  input logic              sqw_en,
  input logic              flag_clr,
  input logic              flag_set,
  input logic              pflag,
  input logic              irq,
  input logic              sqw_pulse
);
  assert_code0_silent_R1: assert property (@(posedge clk) disable iff (rst)
    (rate_code == '0) |=> !flag_set);

  assert_flag_held_R6: assert property (@(posedge clk) disable iff (rst)
    (pflag && !flag_clr) |=> pflag);

  assert_irq_needs_pie_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(pie_en));

  assert_pulse_with_event_R8: assert property (@(posedge clk) disable iff (rst)
    sqw_pulse |-> (flag_set && $past(sqw_en)));

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (rst)
    flag_set |=> !flag_set);

  assert_idle_tick_silent_R11: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> !flag_set);

endmodule

bind periodic_irq_gen periodic_irq_gen_chk #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick_en   (tick_en),
  .rate_code (rate_code),
  .pie_en    (pie_en),
  .sqw_en    (sqw_en),
  .flag_clr  (flag_clr),
  .flag_set  (flag_set),
  .pflag     (pflag),
  .irq       (irq),
  .sqw_pulse (sqw_pulse)
);

// File: tb/tb_periodic_irq_gen.sv
module tb_periodic_irq_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic       pie_en = 1'b0;
  logic       sqw_en = 1'b0;
  logic       sqw_attached = 1'b0;
  logic       flag_clr = 1'b0;
  logic       flag_set, pflag, irq, sqw_pulse;

  int n_cmp = 0;
  int n_bad = 0;
  int mcnt = 0;
  bit mflag = 0;
  bit mirq = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  periodic_irq_gen dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .rate_code(rate_code),
    .pie_en(pie_en), .sqw_en(sqw_en), .sqw_attached(sqw_attached),
    .flag_clr(flag_clr), .flag_set(flag_set), .pflag(pflag),
    .irq(irq), .sqw_pulse(sqw_pulse)
  );

  function automatic int period_of(input int c);
    int e;
    if (c == 0) return 0;
    e = (c < 3) ? 3 : c;
    return 1 << (e - 1);
  endfunction

  task automatic chk(input string tag, input string nm, input bit act, input bit exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, nm, act, exp);
    end
  endtask

  // One clock cycle: drive at negedge, compare after the posedge.
  task automatic step(input bit tk, input bit cl, input string tag);
    int  per, nxt;
    bit  run, ev;
    @(negedge clk);
    tick_en  = tk;
    flag_clr = cl;
    per = period_of(int'(rate_code));
    run = (per != 0) && (pie_en || (sqw_en && sqw_attached));
    nxt = (mcnt + 1) % 32768;
    ev  = tk && run && ((nxt % ((per == 0) ? 1 : per)) == 0);
    @(posedge clk);
    #1;
    mflag = ev || (mflag && !cl);
    mirq  = (ev && pie_en) || (mirq && !cl);
    if (tk) mcnt = nxt;
    chk(tag, "flag_set", flag_set, ev);
    chk(tag, "sqw_pulse", sqw_pulse, ev && sqw_en);
    chk(tag, "pflag", pflag, mflag);
    chk(tag, "irq", irq, mirq);
  endtask

  task automatic run_cycles(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog all-requirements actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R10: reset state
    chk("R10", "flag_set", flag_set, 1'b0);
    chk("R10", "pflag", pflag, 1'b0);
    chk("R10", "irq", irq, 1'b0);
    chk("R10", "sqw_pulse", sqw_pulse, 1'b0);

    // R1: code 0 with everything enabled
    pie_en = 1; sqw_en = 1; sqw_attached = 1; rate_code = 0;
    run_cycles(100, "R1");

    // R2: sweep every code 3..15, each over two periods plus some
    for (int c = 3; c <= 15; c++) begin
      rate_code = 4'(c);
      run_cycles(2 * period_of(c) + 3, "R2");
      step(1'b1, 1'b1, "R6");
    end

    // R3: aliased codes
    rate_code = 4'd1; run_cycles(30, "R3");
    rate_code = 4'd2; run_cycles(30, "R3");

    // R4: enable combinations
    rate_code = 4'd3;
    for (int m = 0; m < 8; m++) begin
      pie_en = m[0]; sqw_en = m[1]; sqw_attached = m[2];
      run_cycles(20, "R4");
      step(1'b1, 1'b1, "R7");
    end

    // R7 / R8: sqw only, then pie only
    pie_en = 0; sqw_en = 1; sqw_attached = 1; rate_code = 4'd4;
    run_cycles(40, "R8");
    pie_en = 1; sqw_en = 0;
    run_cycles(40, "R7");

    // R5: rate changes at unaligned counts and paused enables
    rate_code = 4'd6; run_cycles(45, "R5");
    rate_code = 4'd4; run_cycles(27, "R5");
    pie_en = 0; run_cycles(13, "R5");
    pie_en = 1; rate_code = 4'd5; run_cycles(70, "R5");

    // R6: clears landing on and off event cycles
    rate_code = 4'd3; sqw_en = 1;
    for (int i = 0; i < 60; i++) step(1'b1, (i % 3) == 0, "R6");

    // R11: sparse ticks
    for (int i = 0; i < 80; i++) step((i % 2) == 0, 1'b0, "R11");
    for (int i = 0; i < 40; i++) step(1'b0, (i == 5), "R11");

    // R9: strobe shape over a longer mixed run
    rate_code = 4'd7; run_cycles(200, "R9");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule